// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block steps through the column addresses of one SDRAM read or write burst. A command presents a start column, a direction bit and a start strobe. From the next clock on, the block presents one column address per clock, along with a valid flag and a flag that marks the final beat. The addresses wrap inside the aligned block whose size is the burst length. They follow either sequential or interleaved order. A full-page burst instead runs round the whole 256-column row until something stops it.

The burst length, the order and a single-location write mode sit in a small mode store. A load strobe writes that store. Each burst copies its effective length and order when it starts, so a mode load during a burst changes only the bursts that start after it. A stop input ends a burst at the beat shown in that cycle. A new start command may arrive on any clock. It restarts the sequence at once and wins over a stop in the same cycle. Reserved mode encodings make the block fall back to single-beat bursts and raise an error flag.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset, `beatValid`, `beatLast` and `modeError` are 0, and the mode store holds length code 000 (length 1), sequential order and single-location writes off.
- R2: When `cmdStart` is high at a clock edge, the next cycle shows `beatValid`=1 and `beatCol` equal to the `cmdCol` sampled at that edge. Each later edge moves to the next beat. `beatLast` is 1 on the final beat only, and `beatValid` is 0 in the cycle after the final beat unless a new command was accepted.
- R3: With the order bit at 0 (sequential), length codes 000, 001, 010 and 011 give 1, 2, 4 and 8 beats. Beat i shows the start column with its low log2(length) bits replaced by (start + i) mod length, and the upper bits unchanged.
- R4: With the order bit at 1 (interleaved), beat i shows the start column XOR i, for the same lengths as R3.
- R5: Length code 111 with sequential order is a full-page burst. Beat i shows (start + i) mod 256, wrapping from 255 to 0. `beatLast` never rises, and the burst runs until a stop or a new command.
- R6: A high `stopReq` during a cycle that shows a beat makes that beat the final one. `beatValid` is 0 in the next cycle, for any burst length.
- R7: A `cmdStart` during a running burst restarts the burst with the new column in the next cycle, even when `stopReq` is high in the same cycle.
- R8: When the single-location write bit is set, a burst started with `cmdWrite`=1 has exactly one beat, with `beatLast`=1. Read bursts still use the programmed length. `beatWrite` shows the direction of the running burst.
- R9: Length codes 100, 101 and 110, and code 111 with interleaved order, are reserved. While such a mode is held, `modeError` is 1 and every burst has a single beat.
- R10: `modeLoad` at a clock edge captures `modeLenCode`, `modeInterleave` and `modeWriteSingle`. A burst that is already running keeps the length and order it started with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| modeLoad | input | 1 | Mode store write strobe |
| modeLenCode | input | 3 | Burst length code |
| modeInterleave | input | 1 | Order bit: 0 sequential, 1 interleaved |
| modeWriteSingle | input | 1 | Single-location write bursts when 1 |
| cmdStart | input | 1 | Start a burst (read or write command) |
| cmdWrite | input | 1 | Direction of the started burst: 1 write |
| cmdCol | input | 8 | Start column |
| stopReq | input | 1 | End the running burst after the current beat |
| beatValid | output | 1 | A beat is presented this cycle |
| beatCol | output | 8 | Column address of the current beat |
| beatLast | output | 1 | Current beat is the final beat of the burst |
| beatWrite | output | 1 | Current burst is a write |
| modeError | output | 1 | Mode store holds a reserved encoding |

## Verification
The assertions assume that inputs change only between clock edges. They also assume that the order and length bits are stable within a burst, which the block guarantees itself by copying them at start. The stepping assertions assume that `stopReq` and `cmdStart` are the only ways a burst can end early. The bench drives every input on the falling edge and reads outputs on the falling edge. It loads the mode only at chosen points, including once during a burst to test R10. It mixes stop and start in the same cycle only in the restart scenario, where R7 defines the priority.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

  typedef enum logic [2:0] {
    LEN_ONE   = 3'b000,
    LEN_TWO   = 3'b001,
    LEN_FOUR  = 3'b010,
    LEN_EIGHT = 3'b011,
    LEN_PAGE  = 3'b111
  } lenCode_e;

  typedef struct packed {
    logic load;       // capture start column and burst settings
    logic step;       // advance to the next beat
    logic fullPage;   // burst is a full-page burst
    logic interleave; // interleaved order
    logic write;      // burst direction
  } colStrobes_t;

endpackage

// File: rtl/colgen_ctrl.sv
module colgen_ctrl
  import colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeLoad,
  input  logic [2:0]       modeLenCode,
  input  logic             modeInterleave,
  input  logic             modeWriteSingle,
  input  logic             cmdStart,
  input  logic             cmdWrite,
  input  logic             stopReq,
  input  logic             atLast,
  output colStrobes_t      strb,
  output logic [COL_W-1:0] lenMask,
  output logic             burstActive,
  output logic             beatLast,
  output logic             modeError
);

  logic [2:0]       lenCodeQ;
  logic             ilvQ;
  logic             wsQ;
  logic             activeQ;
  logic [COL_W-1:0] progMask;
  logic             progPage;
  logic             progBad;
  logic             singleWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenCodeQ <= LEN_ONE;
      ilvQ     <= 1'b0;
      wsQ      <= 1'b0;
    end else if (modeLoad) begin
      lenCodeQ <= modeLenCode;
      ilvQ     <= modeInterleave;
      wsQ      <= modeWriteSingle;
    end
  end

  // decode of the stored mode into a wrap mask
  always_comb begin
    progMask = '0;
    progPage = 1'b0;
    progBad  = 1'b0;
    case (lenCodeQ)
      LEN_ONE, LEN_TWO, LEN_FOUR, LEN_EIGHT:
        progMask = COL_W'((32'd1 << lenCodeQ[1:0]) - 32'd1);
      LEN_PAGE: begin
        if (ilvQ) progBad = 1'b1;
        else begin
          progMask = '1;
          progPage = 1'b1;
        end
      end
      default: progBad = 1'b1;
    endcase
  end

  assign singleWrite = cmdWrite & wsQ;
  assign lenMask     = singleWrite ? '0 : progMask;

  always_comb begin
    strb            = '0;
    strb.load       = cmdStart;
    strb.step       = activeQ & ~cmdStart & ~stopReq & ~atLast;
    strb.fullPage   = progPage & ~singleWrite;
    strb.interleave = ilvQ;
    strb.write      = cmdWrite;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               activeQ <= 1'b0;
    else if (cmdStart)       activeQ <= 1'b1;
    else if (stopReq)        activeQ <= 1'b0;
    else if (activeQ && atLast) activeQ <= 1'b0;
  end

  assign burstActive = activeQ;
  assign beatLast    = activeQ & atLast;
  assign modeError   = progBad;

  p_stop_ends_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stopReq && !cmdStart) |=> !burstActive);

  p_restart_r7: assert property (@(posedge clk) disable iff (!rstN)
    cmdStart |=> burstActive);

  p_last_ends_r2: assert property (@(posedge clk) disable iff (!rstN)
    (beatLast && !cmdStart) |=> !burstActive);

  p_single_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStart && cmdWrite && wsQ) |=> beatLast);

  p_reserved_len1_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStart && modeError) |=> beatLast);

endmodule

// File: rtl/colgen_dpath.sv
module colgen_dpath
  import colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  colStrobes_t      strb,
  input  logic [COL_W-1:0] lenMask,
  input  logic [COL_W-1:0] startCol,
  output logic [COL_W-1:0] beatCol,
  output logic             atLast,
  output logic             beatWrite
);

  logic [COL_W-1:0] baseQ;
  logic [COL_W-1:0] cntQ;
  logic [COL_W-1:0] maskQ;
  logic             pageQ;
  logic             ilvQ;
  logic             wrQ;
  logic [COL_W-1:0] seqSum;
  logic [COL_W-1:0] seqCol;
  logic [COL_W-1:0] ilvCol;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ <= '0;
      cntQ  <= '0;
      maskQ <= '0;
      pageQ <= 1'b0;
      ilvQ  <= 1'b0;
      wrQ   <= 1'b0;
    end else if (strb.load) begin
      baseQ <= startCol;
      cntQ  <= '0;
      maskQ <= lenMask;
      pageQ <= strb.fullPage;
      ilvQ  <= strb.interleave;
      wrQ   <= strb.write;
    end else if (strb.step) begin
      cntQ  <= cntQ + COL_W'(1);
    end
  end

  assign seqSum = baseQ + cntQ;

  // per-bit choice: bits inside the wrap mask take the moving part
  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    assign seqCol[b] = maskQ[b] ? seqSum[b] : baseQ[b];
    assign ilvCol[b] = baseQ[b] ^ cntQ[b];
  end

  assign beatCol   = ilvQ ? ilvCol : seqCol;
  assign atLast    = ~pageQ & (cntQ == maskQ);
  assign beatWrite = wrQ;

  p_load_col_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (beatCol == $past(startCol)));

  p_seq_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && !ilvQ) |=>
      (((beatCol & maskQ) == (($past(beatCol) + COL_W'(1)) & maskQ)) &&
       ((beatCol & ~maskQ) == ($past(beatCol) & ~maskQ))));

  p_ilv_block_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && ilvQ) |=>
      (((beatCol & ~maskQ) == ($past(beatCol) & ~maskQ)) && (beatCol != $past(beatCol))));

  p_page_no_end_r5: assert property (@(posedge clk) disable iff (!rstN)
    pageQ |-> !atLast);

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeLoad,
  input  logic [2:0]       modeLenCode,
  input  logic             modeInterleave,
  input  logic             modeWriteSingle,
  input  logic             cmdStart,
  input  logic             cmdWrite,
  input  logic [COL_W-1:0] cmdCol,
  input  logic             stopReq,
  output logic             beatValid,
  output logic [COL_W-1:0] beatCol,
  output logic             beatLast,
  output logic             beatWrite,
  output logic             modeError
);

  colStrobes_t      strb;
  logic [COL_W-1:0] lenMask;
  logic             atLast;

  colgen_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .modeLoad       (modeLoad),
    .modeLenCode    (modeLenCode),
    .modeInterleave (modeInterleave),
    .modeWriteSingle(modeWriteSingle),
    .cmdStart       (cmdStart),
    .cmdWrite       (cmdWrite),
    .stopReq        (stopReq),
    .atLast         (atLast),
    .strb           (strb),
    .lenMask        (lenMask),
    .burstActive    (beatValid),
    .beatLast       (beatLast),
    .modeError      (modeError)
  );

  colgen_dpath #(.COL_W(COL_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .lenMask  (lenMask),
    .startCol (cmdCol),
    .beatCol  (beatCol),
    .atLast   (atLast),
    .beatWrite(beatWrite)
  );

endmodule

// File: tb/sdram_burst_colgen_test.sv
module sdram_burst_colgen_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       modeLoad = 1'b0;
  logic [2:0] modeLenCode = 3'b000;
  logic       modeInterleave = 1'b0;
  logic       modeWriteSingle = 1'b0;
  logic       cmdStart = 1'b0;
  logic       cmdWrite = 1'b0;
  logic [7:0] cmdCol = 8'h00;
  logic       stopReq = 1'b0;
  logic       beatValid;
  logic [7:0] beatCol;
  logic       beatLast;
  logic       beatWrite;
  logic       modeError;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  sdram_burst_colgen uut (
    .clk(clk), .rstN(rstN), .modeLoad(modeLoad), .modeLenCode(modeLenCode),
    .modeInterleave(modeInterleave), .modeWriteSingle(modeWriteSingle),
    .cmdStart(cmdStart), .cmdWrite(cmdWrite), .cmdCol(cmdCol), .stopReq(stopReq),
    .beatValid(beatValid), .beatCol(beatCol), .beatLast(beatLast),
    .beatWrite(beatWrite), .modeError(modeError)
  );

  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] expCol(input logic [7:0] s, input int i,
                                        input logic [7:0] m, input bit ilv);
    logic [7:0] idx = 8'(i);
    if (ilv) return s ^ idx;
    return (s & ~m) | (8'(s + idx) & m);
  endfunction

  task automatic loadMode(input logic [2:0] code, input bit ilv, input bit ws);
    @(negedge clk);
    modeLoad = 1'b1; modeLenCode = code; modeInterleave = ilv; modeWriteSingle = ws;
    @(negedge clk);
    modeLoad = 1'b0;
  endtask

  // issue a command; returns at the falling edge where beat 0 is shown
  task automatic doStart(input logic [7:0] col, input bit wr);
    @(negedge clk);
    cmdStart = 1'b1; cmdCol = col; cmdWrite = wr;
    @(negedge clk);
    cmdStart = 1'b0; cmdWrite = 1'b0;
  endtask

  // checks n beats; returns at the falling edge of the last checked beat
  task automatic expectBeats(input string tag, input logic [7:0] s, input int n,
                             input logic [7:0] m, input bit ilv, input bit lastAtEnd,
                             input bit wr);
    for (int i = 0; i < n; i++) begin
      check({tag, " valid"}, beatValid, 1);
      check({tag, " col"}, beatCol, expCol(s, i, m, ilv));
      check({tag, " last"}, beatLast, (lastAtEnd && i == n - 1));
      check({tag, " write"}, beatWrite, wr);
      if (i != n - 1) @(negedge clk);
    end
  endtask

  task automatic expectIdle(input string tag);
    @(negedge clk);
    check({tag, " idle"}, beatValid, 0);
  endtask

  task automatic testReset;
    check("R1 valid", beatValid, 0);
    check("R1 last", beatLast, 0);
    check("R1 error", modeError, 0);
    doStart(8'h5A, 1'b0);
    expectBeats("R1 default length 1", 8'h5A, 1, 8'h00, 0, 1, 0);
    expectIdle("R1");
  endtask

  task automatic testSequential;
    loadMode(3'b001, 0, 0);
    doStart(8'h13, 1'b0);
    expectBeats("R3 seq len2", 8'h13, 2, 8'h01, 0, 1, 0);
    expectIdle("R2 len2");
    loadMode(3'b010, 0, 0);
    doStart(8'h0E, 1'b1);
    // fixed vectors for R3: 0E 0F 0C 0D
    check("R3 seq len4 beat0", beatCol, 8'h0E); @(negedge clk);
    check("R3 seq len4 beat1", beatCol, 8'h0F); @(negedge clk);
    check("R3 seq len4 beat2", beatCol, 8'h0C); @(negedge clk);
    check("R3 seq len4 beat3", beatCol, 8'h0D);
    check("R2 len4 last", beatLast, 1);
    check("R8 write flag", beatWrite, 1);
    expectIdle("R2 len4");
    loadMode(3'b011, 0, 0);
    doStart(8'hC5, 1'b0);
    expectBeats("R3 seq len8", 8'hC5, 8, 8'h07, 0, 1, 0);
    expectIdle("R2 len8");
  endtask

  task automatic testInterleave;
    loadMode(3'b011, 1, 0);
    doStart(8'h35, 1'b0);
    // fixed vectors for R4: 35 34 37 36 31 30 33 32
    check("R4 ilv len8 beat0", beatCol, 8'h35); @(negedge clk);
    check("R4 ilv len8 beat1", beatCol, 8'h34); @(negedge clk);
    check("R4 ilv len8 beat2", beatCol, 8'h37); @(negedge clk);
    check("R4 ilv len8 beat3", beatCol, 8'h36); @(negedge clk);
    check("R4 ilv len8 beat4", beatCol, 8'h31); @(negedge clk);
    check("R4 ilv len8 beat5", beatCol, 8'h30); @(negedge clk);
    check("R4 ilv len8 beat6", beatCol, 8'h33); @(negedge clk);
    check("R4 ilv len8 beat7", beatCol, 8'h32);
    check("R4 ilv len8 last", beatLast, 1);
    expectIdle("R4 len8");
    loadMode(3'b010, 1, 0);
    doStart(8'hA2, 1'b0);
    expectBeats("R4 ilv len4", 8'hA2, 4, 8'h03, 1, 1, 0);
    expectIdle("R4 len4");
    check("R4 mode error", modeError, 0);
  endtask

  task automatic testFullPage;
    loadMode(3'b111, 0, 0);
    check("R5 page no error", modeError, 0);
    doStart(8'hFE, 1'b0);
    expectBeats("R5 full page", 8'hFE, 260, 8'hFF, 0, 0, 0);
    stopReq = 1'b1;
    @(negedge clk);
    stopReq = 1'b0;
    check("R6 page stopped", beatValid, 0);
  endtask

  task automatic testStop;
    loadMode(3'b011, 0, 0);
    doStart(8'h20, 1'b0);
    expectBeats("R6 stop len8", 8'h20, 3, 8'h07, 0, 0, 0);
    stopReq = 1'b1;
    @(negedge clk);
    stopReq = 1'b0;
    check("R6 stop after beat2", beatValid, 0);
    @(negedge clk);
    check("R6 stays idle", beatValid, 0);
  endtask

  task automatic testRestart;
    loadMode(3'b010, 0, 0);
    doStart(8'h10, 1'b0);
    expectBeats("R7 first", 8'h10, 2, 8'h03, 0, 0, 0);
    cmdStart = 1'b1; cmdCol = 8'h82; stopReq = 1'b1;
    @(negedge clk);
    cmdStart = 1'b0; stopReq = 1'b0;
    expectBeats("R7 restart", 8'h82, 4, 8'h03, 0, 1, 0);
    expectIdle("R7");
  endtask

  task automatic testWriteSingle;
    loadMode(3'b011, 0, 1);
    doStart(8'h45, 1'b1);
    expectBeats("R8 single write", 8'h45, 1, 8'h00, 0, 1, 1);
    expectIdle("R8 write");
    doStart(8'h45, 1'b0);
    expectBeats("R8 read keeps length", 8'h45, 8, 8'h07, 0, 1, 0);
    expectIdle("R8 read");
  endtask

  task automatic testReserved;
    loadMode(3'b101, 0, 0);
    check("R9 error code 101", modeError, 1);
    doStart(8'h23, 1'b0);
    expectBeats("R9 reserved length", 8'h23, 1, 8'h00, 0, 1, 0);
    expectIdle("R9 code 101");
    loadMode(3'b111, 1, 0);
    check("R9 error ilv page", modeError, 1);
    doStart(8'h77, 1'b0);
    expectBeats("R9 ilv page length", 8'h77, 1, 8'h00, 0, 1, 0);
    expectIdle("R9 ilv page");
    loadMode(3'b001, 0, 0);
    check("R9 error cleared", modeError, 0);
  endtask

  task automatic testModeHold;
    loadMode(3'b011, 0, 0);
    doStart(8'h68, 1'b0);
    modeLoad = 1'b1; modeLenCode = 3'b000; modeInterleave = 1'b1;
    check("R10 beat0", beatCol, 8'h68);
    @(negedge clk);
    modeLoad = 1'b0;
    expectBeats("R10 running burst", 8'h69, 7, 8'h07, 0, 1, 0);
    expectIdle("R10");
    doStart(8'h68, 1'b0);
    expectBeats("R10 new mode", 8'h68, 1, 8'h00, 1, 1, 0);
    expectIdle("R10 new");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testSequential();
    testInterleave();
    testFullPage();
    testStop();
    testRestart();
    testWriteSingle();
    testReserved();
    testModeHold();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule